// File: doc/BRIEF.md
# PCI Bus Master Read Engine

This block is the read side of a PCI initiator. A DMA client hands it a start address, a count of 32-bit words, a transfer class (descriptor/initialization data or transmit buffer data) and a few configuration bits. The engine requests the bus and waits for a grant. It then fetches the words from system memory and passes each one back to the client with a one-cycle valid strobe. When the job is over it releases the bus and pulses a done signal.

By default every word is fetched by its own single-data-phase transaction. Several such transactions are chained in one bus tenure, with FRAME high between them. When bursting is enabled, and the class allows it, the whole job is one burst transaction. The burst uses a command picked from the class and a command-select bit. The point at which REQ is withdrawn depends on the mode and on an extended-request bit. The shared bus lines are modelled as separate output, output-enable and input ports.

Top module: `pci_rd_master`

## Requirements
- R1: With burst disabled, every word is fetched by its own transaction with one data phase. FRAME is high whenever IRDY is low, and the address phase carries command 4'b0110 on C/BE.
- R2: A burst is used only when the burst-enable bit is set, and either the class is transmit buffer (xfer_tx=1) or the descriptor style input equals 8'd3. A descriptor read with burst enabled and any other style value is done as non-burst transactions.
- R3: A burst of descriptor/initialization data uses command 4'b0110. A burst of transmit data uses 4'b1110 when cfg_memcmd=0 and 4'b1100 when cfg_memcmd=1.
- R4: Every address phase drives AD[1:0]=2'b00, with AD[31:2] equal to the start address plus 4 per word already received. C/BE is 4'b0000 (all lanes enabled) in every data phase.
- R5: IRDY is driven low in the clock right after each address phase.
- R6: In a burst, FRAME stays low until the next-to-last data phase completes. Exactly one accepted data phase (the last) sees FRAME high with IRDY low.
- R7: In non-burst mode, REQ stays low through every address phase except that of the last word, and is high from the last address phase onward.
- R8: In burst mode with cfg_extreq=0, REQ goes high in the clock FRAME is first asserted. With cfg_extreq=1, REQ stays low until the last data phase begins, then goes high.
- R9: Once REQ is low it stays low until GNT is seen, even if halt is raised; a halted job then ends with done and no address phase. soft_rst drives REQ high in the same cycle and returns the engine to idle.
- R10: A data phase completes only in a clock where IRDY, TRDY and DEVSEL are all low. Each word is presented on rdata with rvalid one clock later, in address order, exactly word_cnt times.
- R11: An address phase starts only after a clock in which GNT was low and both FRAME and IRDY on the bus were high.
- R12: After the last data phase, done is high for exactly one clock. In the next clock, AD, C/BE, FRAME and IRDY are all undriven. After reset REQ is high and nothing is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; forces REQ high at once |
| start | input | 1 | Begin a job (taken in idle when word_cnt is non-zero) |
| start_addr | input | 32 | Byte address of the first word |
| word_cnt | input | CW | Number of 32-bit words to read |
| xfer_tx | input | 1 | Class: 1 transmit buffer, 0 descriptor/initialization |
| cfg_burst | input | 1 | Burst enable |
| cfg_style | input | 8 | Descriptor style; bursts of descriptors need 3 |
| cfg_memcmd | input | 1 | Transmit burst command select |
| cfg_extreq | input | 1 | Hold REQ through a burst |
| halt | input | 1 | Abandon a job that is still waiting for grant |
| rdata | output | 32 | Received word |
| rvalid | output | 1 | rdata is valid |
| done | output | 1 | One-cycle end-of-job pulse |
| busy | output | 1 | Job in progress |
| req_n | output | 1 | Bus request |
| gnt_n | input | 1 | Bus grant |
| frame_n_i | input | 1 | FRAME as seen on the bus |
| irdy_n_i | input | 1 | IRDY as seen on the bus |
| devsel_n | input | 1 | Target device select |
| trdy_n | input | 1 | Target ready |
| ad_i | input | 32 | AD bus input |
| ad_o | output | 32 | AD bus output |
| ad_oe | output | 1 | AD output enable |
| cbe_o | output | 4 | Command / byte enables |
| cbe_oe | output | 1 | C/BE output enable |
| frame_n_o | output | 1 | FRAME output |
| frame_oe | output | 1 | FRAME output enable |
| irdy_n_o | output | 1 | IRDY output |
| irdy_oe | output | 1 | IRDY output enable |

## Verification
The hard case is a job whose last data phase coincides with the REQ release. With cfg_extreq set, REQ must rise in the very clock the final data phase starts, while FRAME goes high in that same clock. The bench provokes this with bursts of several lengths and with 0 to 2 target wait states. On each data-phase clock it compares REQ against the number of words still outstanding, and it counts the accepted phases that see FRAME high. A second overlap is halt arriving while the engine is still waiting for grant. The bench checks that REQ stays low until grant is given and that the job then ends with no address phase.

// File: rtl/pci_rd_master.sv
module pci_rd_master #(
  parameter int CW          = 8,
  parameter int BURST_STYLE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          start,
  input  logic [31:0]   start_addr,
  input  logic [CW-1:0] word_cnt,
  input  logic          xfer_tx,
  input  logic          cfg_burst,
  input  logic [7:0]    cfg_style,
  input  logic          cfg_memcmd,
  input  logic          cfg_extreq,
  input  logic          halt,
  output logic [31:0]   rdata,
  output logic          rvalid,
  output logic          done,
  output logic          busy,
  output logic          req_n,
  input  logic          gnt_n,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic          devsel_n,
  input  logic          trdy_n,
  input  logic [31:0]   ad_i,
  output logic [31:0]   ad_o,
  output logic          ad_oe,
  output logic [3:0]    cbe_o,
  output logic          cbe_oe,
  output logic          frame_n_o,
  output logic          frame_oe,
  output logic          irdy_n_o,
  output logic          irdy_oe
);

  localparam logic [3:0] CMD_MR  = 4'b0110;
  localparam logic [3:0] CMD_MRL = 4'b1110;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [7:0] STYLE_B = 8'(BURST_STYLE);
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_REQW, S_ADDR, S_DATA, S_GAP, S_TURN} st_t;

  st_t          st;
  logic [31:2]  addr_q;
  logic [CW-1:0] rem_q;
  logic         burst_q;
  logic         ext_q;
  logic         halt_q;
  logic [3:0]   cmd_q;
  logic [31:0]  rdata_q;
  logic         rvalid_q;

  logic use_burst, last, accept, bus_free, req_c;
  logic [3:0] cmd_sel;

  assign use_burst = cfg_burst & (xfer_tx | (cfg_style == STYLE_B));
  assign cmd_sel   = !use_burst ? CMD_MR :
                     !xfer_tx   ? CMD_MR :
                     cfg_memcmd ? CMD_MRM : CMD_MRL;
  assign last      = (rem_q == ONE);
  assign accept    = (st == S_DATA) & ~trdy_n & ~devsel_n;
  assign bus_free  = ~gnt_n & frame_n_i & irdy_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      burst_q  <= 1'b0;
      ext_q    <= 1'b0;
      halt_q   <= 1'b0;
      cmd_q    <= CMD_MR;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else if (soft_rst) begin
      st       <= S_IDLE;
      halt_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= accept;
      if (accept) rdata_q <= ad_i;
      case (st)
        S_IDLE: begin
          halt_q <= 1'b0;
          if (start && word_cnt != '0) begin
            addr_q  <= start_addr[31:2];
            rem_q   <= word_cnt;
            burst_q <= use_burst;
            ext_q   <= cfg_extreq;
            cmd_q   <= cmd_sel;
            st      <= S_REQW;
          end
        end
        S_REQW: begin
          halt_q <= halt_q | halt;
          if (!gnt_n && (halt_q || halt)) st <= S_TURN;
          else if (bus_free)              st <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (accept) begin
            addr_q <= addr_q + 30'd1;
            rem_q  <= rem_q - ONE;
            if (last)          st <= S_TURN;
            else if (!burst_q) st <= S_GAP;
          end
        end
        S_GAP:  st <= gnt_n ? S_REQW : S_ADDR;
        S_TURN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_c = 1'b0;
    case (st)
      S_REQW: req_c = 1'b1;
      S_ADDR: req_c = burst_q ? (ext_q & ~last) : ~last;
      S_DATA: req_c = (burst_q & ~ext_q) ? 1'b0 : ~last;
      S_GAP:  req_c = 1'b1;
      default: req_c = 1'b0;
    endcase
  end

  assign req_n     = ~(req_c & ~soft_rst);
  assign ad_o      = {addr_q, 2'b00};
  assign ad_oe     = (st == S_ADDR);
  assign cbe_o     = (st == S_ADDR) ? cmd_q : 4'b0000;
  assign cbe_oe    = (st == S_ADDR) | (st == S_DATA);
  assign frame_oe  = (st == S_ADDR) | (st == S_DATA) | (st == S_GAP) | (st == S_TURN);
  assign irdy_oe   = frame_oe;
  assign frame_n_o = ~((st == S_ADDR) | ((st == S_DATA) & burst_q & ~last));
  assign irdy_n_o  = ~(st == S_DATA);
  assign done      = (st == S_TURN);
  assign busy      = (st != S_IDLE);
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;

endmodule

// File: rtl/pci_rd_master_chk.sv
module pci_rd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        req_n,
  input logic        gnt_n,
  input logic        frame_n_i,
  input logic        irdy_n_i,
  input logic        devsel_n,
  input logic        trdy_n,
  input logic        rvalid,
  input logic        done,
  input logic [31:0] ad_o,
  input logic        ad_oe,
  input logic [3:0]  cbe_o,
  input logic        cbe_oe,
  input logic        frame_n_o,
  input logic        frame_oe,
  input logic        irdy_n_o,
  input logic        irdy_oe
);
  logic aph, dph;
  assign aph = frame_oe & ~frame_n_o & irdy_oe & irdy_n_o;
  assign dph = irdy_oe & ~irdy_n_o;

  p_irdy_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    aph |=> (irdy_oe && !irdy_n_o));

  p_ad_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    aph |-> (ad_oe && ad_o[1:0] == 2'b00));

  p_lanes_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dph |-> (cbe_oe && cbe_o == 4'b0000));

  p_cmd_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    aph |-> (cbe_o == 4'b0110 || cbe_o == 4'b1110 || cbe_o == 4'b1100));

  p_grant_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_oe) |-> $past(!gnt_n && frame_n_i && irdy_n_i));

  p_word_accept_r10: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    rvalid |-> $past(dph && !trdy_n && !devsel_n));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done |=> !done);

  p_release_r12: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    done |=> (!ad_oe && !cbe_oe && !frame_oe && !irdy_oe));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && gnt_n && !frame_oe && !soft_rst) |=> (!req_n || soft_rst));

  p_soft_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> req_n);
endmodule

bind pci_rd_master pci_rd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_n(req_n), .gnt_n(gnt_n),
  .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .devsel_n(devsel_n), .trdy_n(trdy_n),
  .rvalid(rvalid), .done(done), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o),
  .cbe_oe(cbe_oe), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
  .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe)
);

// File: tb/pci_rd_master_bench.sv
`timescale 1ns/1ps
module pci_rd_master_bench;
  logic clk = 0, rst_n = 0, soft_rst = 0, start = 0;
  logic [31:0] start_addr = 0;
  logic [7:0] word_cnt = 0, cfg_style = 0;
  logic xfer_tx = 0, cfg_burst = 0, cfg_memcmd = 0, cfg_extreq = 0, halt = 0;
  logic [31:0] rdata, ad_i = 0, ad_o;
  logic rvalid, done, busy, req_n, ad_oe, cbe_oe, frame_n_o, frame_oe, irdy_n_o, irdy_oe;
  logic [3:0] cbe_o;
  logic gnt_n = 1, devsel_n = 1, trdy_n = 1, ext_frame_n = 1;
  logic frame_n_i, irdy_n_i;

  assign frame_n_i = ext_frame_n & (frame_oe ? frame_n_o : 1'b1);
  assign irdy_n_i  = irdy_oe ? irdy_n_o : 1'b1;

  always #2.5 clk = ~clk;

  pci_rd_master u_pci_rd_master (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start), .start_addr(start_addr),
    .word_cnt(word_cnt), .xfer_tx(xfer_tx), .cfg_burst(cfg_burst), .cfg_style(cfg_style),
    .cfg_memcmd(cfg_memcmd), .cfg_extreq(cfg_extreq), .halt(halt), .rdata(rdata),
    .rvalid(rvalid), .done(done), .busy(busy), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
    .frame_n_o(frame_n_o), .frame_oe(frame_oe), .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe)
  );

  int n_chk = 0, n_bad = 0;
  int exp_n, waits, wcnt;
  logic [31:0] exp_base, taddr;
  logic [3:0] exp_cmd;
  bit exp_burst, exp_ext, prev_aph;
  int m_addr, m_words, m_rx, m_fhi, m_cmd_bad, m_al_bad, m_be_bad, m_req_bad, m_irdy_bad, m_dbad;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16]} + 32'h0001_3579;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    m_addr = 0; m_words = 0; m_rx = 0; m_fhi = 0; m_cmd_bad = 0; m_al_bad = 0;
    m_be_bad = 0; m_req_bad = 0; m_irdy_bad = 0; m_dbad = 0;
  endtask

  always @(negedge clk) begin
    bit aph;
    int rem;
    bit req_on;
    if (!trdy_n) taddr = taddr + 32'd4;
    if (rvalid) begin
      if (rdata !== memf(exp_base + 32'(4 * m_rx))) m_dbad++;
      m_rx++;
    end
    aph = frame_oe & ~frame_n_o & irdy_oe & irdy_n_o;
    if (prev_aph && !(irdy_oe && !irdy_n_o)) m_irdy_bad++;
    prev_aph = aph;
    trdy_n = 1; devsel_n = 1;
    rem = exp_n - m_words;
    if (aph) begin
      m_addr++;
      if (cbe_o !== exp_cmd) m_cmd_bad++;
      if (ad_o[1:0] !== 2'b00 || ad_o !== exp_base + 32'(4 * m_words)) m_al_bad++;
      req_on = exp_burst ? (exp_ext && rem > 1) : (rem > 1);
      if (req_n !== !req_on) m_req_bad++;
      taddr = ad_o; wcnt = waits;
    end else if (irdy_oe && !irdy_n_o) begin
      if (cbe_o !== 4'b0000 || !cbe_oe) m_be_bad++;
      req_on = (exp_burst && !exp_ext) ? 1'b0 : (rem > 1);
      if (req_n !== !req_on) m_req_bad++;
      devsel_n = 0;
      if (wcnt == 0) begin
        trdy_n = 0; ad_i = memf(taddr); m_words++;
        if (frame_n_o) m_fhi++;
      end else wcnt--;
    end
  end

  task automatic launch(input bit tx, input bit burst, input logic [7:0] style, input bit memcmd,
                        input bit ext, input int n, input logic [31:0] a, input int w);
    exp_burst = burst && (tx || style == 8'd3);
    exp_cmd   = !exp_burst ? 4'b0110 : !tx ? 4'b0110 : memcmd ? 4'b1100 : 4'b1110;
    exp_ext = ext; exp_n = n; exp_base = a; waits = w;
    mon_clear();
    @(negedge clk);
    xfer_tx = tx; cfg_burst = burst; cfg_style = style; cfg_memcmd = memcmd;
    cfg_extreq = ext; word_cnt = 8'(n); start_addr = a; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish(input string tag);
    int t = 0;
    bit seen = 0;
    while (!seen && t < 2000) begin
      @(negedge clk); #1;
      if (done) seen = 1;
      t++;
    end
    check(seen, "R12", {tag, " done seen"}, seen, 1);
    @(negedge clk); #1;
    check(!done, "R12", {tag, " done one cycle"}, done, 0);
    check(!ad_oe && !cbe_oe && !frame_oe && !irdy_oe, "R12", {tag, " drivers off"},
          {ad_oe, cbe_oe, frame_oe, irdy_oe}, 0);
    @(negedge clk); #1;
  endtask

  task automatic judge(input string tag);
    check(m_rx == exp_n && m_dbad == 0, "R10", {tag, " words"}, m_rx - m_dbad, exp_n);
    check(m_cmd_bad == 0, "R3", {tag, " command"}, m_cmd_bad, 0);
    check(m_al_bad == 0 && m_be_bad == 0, "R4", {tag, " address/lanes"}, m_al_bad + m_be_bad, 0);
    check(m_irdy_bad == 0, "R5", {tag, " irdy after addr"}, m_irdy_bad, 0);
    if (exp_burst) begin
      check(m_addr == 1, "R2", {tag, " one burst"}, m_addr, 1);
      check(m_fhi == 1, "R6", {tag, " frame high last"}, m_fhi, 1);
      check(m_req_bad == 0, "R8", {tag, " req burst"}, m_req_bad, 0);
    end else begin
      check(m_addr == exp_n, "R1", {tag, " single phases"}, m_addr, exp_n);
      check(m_fhi == exp_n, "R1", {tag, " frame high"}, m_fhi, exp_n);
      check(m_req_bad == 0, "R7", {tag, " req chain"}, m_req_bad, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    check(req_n && !ad_oe && !cbe_oe && !frame_oe && !irdy_oe && !done && !rvalid && !busy,
          "R12", "reset state", {req_n, ad_oe, frame_oe, busy}, 8);
  endtask

  task automatic t_default();
    launch(0, 0, 8'd0, 0, 0, 3, 32'h0000_1000, 0); finish("default"); judge("default");
  endtask

  task automatic t_desc_fallback();
    launch(0, 1, 8'd2, 0, 1, 4, 32'h0002_0040, 1); finish("fallback"); judge("fallback");
    check(m_addr == 4, "R2", "style not 3 stays non-burst", m_addr, 4);
  endtask

  task automatic t_desc_burst();
    launch(0, 1, 8'd3, 0, 0, 4, 32'h0003_0100, 0); finish("descburst"); judge("descburst");
  endtask

  task automatic t_tx_line();
    launch(1, 1, 8'd0, 0, 1, 5, 32'h0004_0200, 2); finish("txline"); judge("txline");
  endtask

  task automatic t_tx_multi();
    launch(1, 1, 8'd0, 1, 0, 2, 32'h0005_0300, 1); finish("txmulti"); judge("txmulti");
  endtask

  task automatic t_tx_single();
    launch(1, 1, 8'd0, 1, 1, 1, 32'h0006_0010, 0); finish("txsingle"); judge("txsingle");
  endtask

  task automatic t_grant_wait();
    int seen_fr = 0;
    gnt_n = 1;
    launch(0, 0, 8'd0, 0, 0, 2, 32'h0007_0000, 0);
    for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (frame_oe) seen_fr++; end
    check(seen_fr == 0 && !req_n, "R11", "no address without grant", seen_fr, 0);
    ext_frame_n = 0; gnt_n = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1; if (frame_oe) seen_fr++; end
    check(seen_fr == 0, "R11", "no address while bus busy", seen_fr, 0);
    ext_frame_n = 1;
    finish("grantwait"); judge("grantwait");
  endtask

  task automatic t_halt();
    int held = 0;
    gnt_n = 1;
    launch(1, 1, 8'd0, 0, 0, 3, 32'h0008_0000, 0);
    halt = 1;
    @(negedge clk); halt = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); #1; if (!req_n) held++; end
    check(held == 5, "R9", "req held during halt", held, 5);
    gnt_n = 0;
    finish("halt");
    check(m_addr == 0 && m_rx == 0, "R9", "halt no address phase", m_addr + m_rx, 0);
    check(req_n, "R9", "req released after halt", req_n, 1);
  endtask

  task automatic t_soft_reset();
    int act = 0;
    gnt_n = 1;
    launch(0, 0, 8'd0, 0, 0, 2, 32'h0009_0000, 0);
    @(negedge clk); @(negedge clk); #1;
    check(!req_n, "R9", "req low before soft reset", req_n, 0);
    soft_rst = 1; #1;
    check(req_n, "R9", "soft reset drops req at once", req_n, 1);
    @(negedge clk); soft_rst = 0; gnt_n = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); #1; if (busy || frame_oe || !req_n) act++; end
    check(act == 0 && m_addr == 0, "R9", "soft reset returns to idle", act + m_addr, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    exp_n = 0; waits = 0; wcnt = 0; exp_base = 0; taddr = 0; exp_cmd = 4'b0110;
    exp_burst = 0; exp_ext = 0; prev_aph = 0;
    mon_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    gnt_n = 0;
    @(negedge clk);
    t_default();
    t_desc_fallback();
    t_desc_burst();
    t_tx_line();
    t_tx_multi();
    t_tx_single();
    t_grant_wait();
    t_halt();
    gnt_n = 0;
    t_soft_reset();
    summary();
    $finish;
  end
endmodule